// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block drives the active-low reset of a processor. It looks at a synchronized flag that says the main supply is above its trip point, at a watchdog service input coming from the processor, at a strap that says the service input is left floating, and at a slow, millisecond-scale tick from a free-running oscillator. Reset is held low while the supply is under threshold. After the supply recovers, reset is stretched by a fixed delay that is counted in ticks, and then it is released.

While reset is released, a watchdog counts ticks. The processor keeps it alive by toggling the service input. A change in either direction restarts the count. If the count runs out, the block issues a reset pulse. This pulse uses the same delay timer as the supply-recovery stretch, so a watchdog reset and a power-on reset have the same length. When the service input is floating, the block restarts the watchdog by itself at seven eighths of the timeout, so an unused watchdog never fires. The supply check always wins over the watchdog. All delays are parameters in tick counts, so a test can run with short windows.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `clr` is high, `rst_n` is low from the next clock edge on. After `clr` falls, the block runs the supply-recovery sequence of R3.
- R2: While `supply_ok` is low, `rst_n` is low from the next clock edge on, whatever the watchdog state is.
- R3: After `supply_ok` goes high, `rst_n` rises at the clock edge that samples the DELAY_TICKS-th tick. Ticks are counted after the edge that first saw `supply_ok` high, and a tick at that first edge does not count.
- R4: While `rst_n` is high and nothing restarts the watchdog, `rst_n` falls at the edge that samples the TIMEOUT_TICKS-th tick since release or since the last restart.
- R5: A watchdog timeout holds `rst_n` low for DELAY_TICKS ticks, counted as in R3, and then releases it.
- R6: A rising change and a falling change of `wd_in` each restart the watchdog. `wd_in` passes a two-flop synchronizer, so a change sampled at edge k restarts the count at edge k+2.
- R7: While `wd_float` is high, `wd_in` is ignored. The watchdog restarts itself when it samples tick number TIMEOUT_TICKS*7/8 (at least 1), so it never times out.
- R8: A supply drop during the reset stretch or during normal running stops that phase. When the supply returns, the full delay of R3 starts again.
- R9: The watchdog count is zero while `rst_n` is low. Changes of `wd_in` during reset do not shorten or lengthen the timeout window that follows release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous active-high power-on clear |
| supply_ok | input | 1 | Synchronized flag: supply above trip point |
| wd_in | input | 1 | Watchdog service input from the processor |
| wd_float | input | 1 | Static strap: service input is unconnected |
| tick | input | 1 | One-cycle pulse from the slow oscillator |
| rst_n | output | 1 | Active-low processor reset |

## Verification
The bound checker checks these rules on every cycle: reset follows a clear or a low supply, reset releases only on a tick with the supply good, reset falls only for a clear, a low supply or a counter sitting at its last count, the count stays zero during reset and below the timeout, and a floating service input never lets reset fall. Other behaviour needs the bench's scenarios and its cycle-accurate reference model. That covers the exact release and timeout cycles, the two-edge restart (toggling at a rate that only works if both edges count), the three-cycle latency of the synchronizer, and the restarted delay after a supply dip during the stretch.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } supv_state_e;

    // internal keep-alive point: seven eighths of the timeout, never below one tick
    function automatic int keepalive_ticks(input int timeout);
        int k;
        k = (timeout * 7) / 8;
        return (k < 1) ? 1 : k;
    endfunction

endpackage

// File: rtl/supv_wdi_sync.sv
module supv_wdi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic wd_in,
    output logic edge_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (clr) chain <= '0;
                else     chain <= wd_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (clr) chain <= '0;
                else     chain <= {chain[STAGES-2:0], wd_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign edge_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer #(
    parameter int TIMEOUT_TICKS = 800,
    parameter int CNT_W         = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             enable,
    input  logic             tick,
    input  logic             ext_edge,
    input  logic             floating,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    import supv_pkg::*;

    localparam int KEEP = keepalive_ticks(TIMEOUT_TICKS);

    logic keep_hit;
    logic kick;

    assign keep_hit = tick && (cnt == CNT_W'(KEEP - 1));
    assign kick     = floating ? keep_hit : ext_edge;
    assign expire   = enable && tick && !kick && (cnt == CNT_W'(TIMEOUT_TICKS - 1));

    always_ff @(posedge clk) begin
        if (clr || !enable || kick || expire) cnt <= '0;
        else if (tick)                         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/supv_seq_fsm.sv
module supv_seq_fsm #(
    parameter int DELAY_TICKS = 100,
    parameter int DLY_W       = $clog2(DELAY_TICKS + 1)
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  supply_ok,
    input  logic                  tick,
    input  logic                  expire,
    output supv_pkg::supv_state_e state
);
    import supv_pkg::*;

    logic [DLY_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (clr || !supply_ok) begin
            state <= ST_HOLD;
            dly   <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    state <= ST_STRETCH;
                    dly   <= '0;
                end
                ST_STRETCH: begin
                    if (tick) begin
                        if (dly == DLY_W'(DELAY_TICKS - 1)) begin
                            state <= ST_RUN;
                            dly   <= '0;
                        end else begin
                            dly <= dly + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (expire) begin
                        state <= ST_STRETCH;
                        dly   <= '0;
                    end
                end
                default: begin
                    state <= ST_HOLD;
                    dly   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
    parameter int DELAY_TICKS   = 100,
    parameter int TIMEOUT_TICKS = 800,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic supply_ok,
    input  logic wd_in,
    input  logic wd_float,
    input  logic tick,
    output logic rst_n
);
    import supv_pkg::*;

    localparam int DLY_W = $clog2(DELAY_TICKS + 1);
    localparam int WD_W  = $clog2(TIMEOUT_TICKS + 1);

    supv_state_e     state;
    logic            ext_edge;
    logic            expire;
    logic            wd_enable;
    logic [WD_W-1:0] wd_cnt;

    supv_wdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .clr    (clr),
        .wd_in  (wd_in),
        .edge_o (ext_edge)
    );

    assign wd_enable = (state == ST_RUN) && supply_ok;

    supv_wd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(WD_W)) u_wd (
        .clk      (clk),
        .clr      (clr),
        .enable   (wd_enable),
        .tick     (tick),
        .ext_edge (ext_edge),
        .floating (wd_float),
        .expire   (expire),
        .cnt      (wd_cnt)
    );

    supv_seq_fsm #(.DELAY_TICKS(DELAY_TICKS), .DLY_W(DLY_W)) u_fsm (
        .clk       (clk),
        .clr       (clr),
        .supply_ok (supply_ok),
        .tick      (tick),
        .expire    (expire),
        .state     (state)
    );

    assign rst_n = (state == ST_RUN);
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int TIMEOUT_TICKS = 800,
    parameter int CNT_W         = 10
) (
    input logic             clk,
    input logic             clr,
    input logic             supply_ok,
    input logic             wd_float,
    input logic             tick,
    input logic             rst_n,
    input logic [CNT_W-1:0] wd_cnt
);
    p_clear_low_r1: assert property (@(posedge clk) clr |=> !rst_n);

    p_supply_low_r2: assert property (@(posedge clk) disable iff (clr)
        !supply_ok |=> !rst_n);

    p_release_on_tick_r3: assert property (@(posedge clk) disable iff (clr)
        $rose(rst_n) |-> ($past(tick) && $past(supply_ok)));

    p_fall_cause_r4: assert property (@(posedge clk) disable iff (clr)
        $fell(rst_n) |-> ($past(clr) || !$past(supply_ok) ||
                          ($past(tick) && $past(wd_cnt) == CNT_W'(TIMEOUT_TICKS - 1))));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (clr)
        wd_cnt < CNT_W'(TIMEOUT_TICKS));

    p_float_alive_r7: assert property (@(posedge clk) disable iff (clr)
        (rst_n && supply_ok && wd_float) |=> rst_n);

    p_cnt_held_r9: assert property (@(posedge clk) disable iff (clr)
        !rst_n |-> (wd_cnt == '0));
endmodule

bind supv_reset_ctrl supv_reset_chk #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .CNT_W         (WD_W)
) u_chk (
    .clk       (clk),
    .clr       (clr),
    .supply_ok (supply_ok),
    .wd_float  (wd_float),
    .tick      (tick),
    .rst_n     (rst_n),
    .wd_cnt    (wd_cnt)
);

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 5;
    localparam int TMO        = 16;
    localparam int KEEP       = (TMO * 7) / 8;
    localparam int DIV        = 4;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic supply_ok = 1'b0;
    logic wd_in = 1'b0;
    logic wd_float = 1'b0;
    logic tick = 1'b0;
    logic rst_n;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    supv_reset_ctrl #(.DELAY_TICKS(DELAY), .TIMEOUT_TICKS(TMO), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .clr(clr), .supply_ok(supply_ok), .wd_in(wd_in),
        .wd_float(wd_float), .tick(tick), .rst_n(rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick source: one cycle in DIV
    initial begin
        forever begin
            repeat (DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // behavioural reference model
    int m_state = 0;   // 0 held, 1 delay, 2 running
    int m_dly = 0;
    int m_wdc = 0;
    int wq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit edge_seen, kick, expire;
        edge_seen = (wq[1] != wq[2]);
        wq.push_front(int'(wd_in));
        void'(wq.pop_back());
        if (clr) begin
            m_state = 0; m_dly = 0; m_wdc = 0;
            wq = '{0, 0, 0};
        end else if (!supply_ok) begin
            m_state = 0; m_dly = 0; m_wdc = 0;
        end else begin
            kick   = wd_float ? (tick && m_wdc == KEEP - 1) : edge_seen;
            expire = (m_state == 2) && tick && !kick && (m_wdc == TMO - 1);
            case (m_state)
                0: begin m_state = 1; m_dly = 0; end
                1: if (tick) begin
                       if (m_dly == DELAY - 1) begin m_state = 2; m_dly = 0; m_wdc = 0; end
                       else m_dly++;
                   end
                default: begin
                    if (expire) begin m_state = 1; m_dly = 0; m_wdc = 0; end
                    else if (kick) m_wdc = 0;
                    else if (tick) m_wdc++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        checks++;
        if (rst_n !== (m_state == 2)) begin
            fails++;
            $display("FAIL %s model compare at %0t: rst_n=%b expected=%b",
                     cur_req, $time, rst_n, (m_state == 2));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycles until rst_n reaches level, bounded
    task automatic wait_level(input bit lvl, output int n);
        n = 0;
        while (rst_n !== lvl && n < 4000) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        int n;
        int lows;
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int lows;
        // R1: clear holds reset
        step(3);
        chk(rst_n === 1'b0, "R1", rst_n, 0);
        clr = 1'b0;
        step(2);
        chk(rst_n === 1'b0, "R2", rst_n, 0);

        // R3: release after delay
        cur_req = "R3";
        supply_ok = 1'b1;
        wait_level(1'b1, n);
        chk(n >= (DELAY - 1) * DIV && n <= (DELAY + 1) * DIV + 2, "R3", n, DELAY * DIV);

        // R6: toggling every 10 ticks keeps it alive only if both edges count
        cur_req = "R6";
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 10 * DIV; c++) begin
                step(1);
                if (rst_n !== 1'b1) lows++;
            end
            wd_in = ~wd_in;
        end
        chk(lows == 0, "R6", lows, 0);

        // R4: stop servicing, timeout
        cur_req = "R4";
        wait_level(1'b0, n);
        chk(n >= (TMO - 1) * DIV && n <= (TMO + 1) * DIV + 4, "R4", n, TMO * DIV);

        // R5 and R9: pulse length, edges during reset ignored
        cur_req = "R5";
        step(2);
        wd_in = ~wd_in;
        wait_level(1'b1, n);
        n += 2;
        chk(n >= (DELAY - 1) * DIV && n <= (DELAY + 1) * DIV + 2, "R5", n, DELAY * DIV);
        cur_req = "R9";
        wait_level(1'b0, n);
        chk(n >= (TMO - 1) * DIV && n <= (TMO + 1) * DIV, "R9", n, TMO * DIV);

        // R7: floating input, internal keep-alive
        cur_req = "R7";
        wd_float = 1'b1;
        wait_level(1'b1, n);
        lows = 0;
        for (int c = 0; c < 5 * TMO * DIV; c++) begin
            step(1);
            if (rst_n !== 1'b1) lows++;
            if (c % 7 == 0) wd_in = ~wd_in;
        end
        chk(lows == 0, "R7", lows, 0);
        wd_float = 1'b0;

        // R2 and R8: supply drop overrides
        cur_req = "R2";
        supply_ok = 1'b0;
        step(1);
        chk(rst_n === 1'b0, "R2", rst_n, 0);
        cur_req = "R8";
        lows = 0;
        for (int c = 0; c < 20 * DIV; c++) begin
            step(1);
            if (rst_n !== 1'b0) lows++;
            if (c % 3 == 0) wd_in = ~wd_in;
        end
        chk(lows == 0, "R8", lows, 0);
        supply_ok = 1'b1;
        step(3 * DIV);
        supply_ok = 1'b0;
        step(2);
        chk(rst_n === 1'b0, "R8", rst_n, 0);
        supply_ok = 1'b1;
        wait_level(1'b1, n);
        chk(n >= (DELAY - 1) * DIV && n <= (DELAY + 1) * DIV + 2, "R8", n, DELAY * DIV);

        // R1: clear while running
        cur_req = "R1";
        step(5);
        clr = 1'b1;
        step(1);
        chk(rst_n === 1'b0, "R1", rst_n, 0);
        step(3);
        chk(rst_n === 1'b0, "R1", rst_n, 0);
        clr = 1'b0;
        wait_level(1'b1, n);
        chk(n >= (DELAY - 1) * DIV && n <= (DELAY + 1) * DIV + 2, "R1", n, DELAY * DIV);
        step(10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule